// File: doc/BRIEF.md
# Oversampled Framed Character Receiver

This block recovers bytes from a single-wire serial input that is sampled four times per bit period. A sample strobe from outside marks each sampling instant, and the receiver looks at the line only on a strobe. A frame opens with a long low stretch followed by a return to high. Ten-bit characters follow. Each character is a low start bit, eight data bits with the least significant first, and a high stop bit. A character whose ten bits are all low closes the frame.

Each good character produces a one-cycle byte strobe with the byte alongside it. A properly closed frame that carried at least one byte produces a one-cycle completion pulse. The receiver returns to idle and raises a one-cycle error pulse in three cases: a malformed character, an over-long quiet gap while a character is expected, and a frame that reaches the configured byte limit. A low stretch that does not qualify as a frame opening is dropped silently.

Top module: `sofeof_rx`

## Requirements
- R1: The input is sampled only on cycles where `smp_en` is 1. Within each bit, counting the sample that begins the bit as index 0, the bit value is the one taken at index 2. Samples at indices 0, 1 and 3 do not change the recovered data.
- R2: A frame opening is accepted only when the first high sample at a bit-sampling point (index 2) follows 10, 11 or 12 low sampling points. With 9 or fewer, the receiver goes back to idle silently. On the 13th low sampling point it also goes back to idle silently.
- R3: A character is valid when its sampled start bit is 0 and its stop bit is 1. Its eight data bits are sent least significant first. `byte_data` then holds the byte while `byte_vld` is 1 for one cycle, in the cycle after the strobe that sampled the stop bit.
- R4: A character whose ten sampled bits are all 0 ends the frame. `frame_done` pulses for one cycle only if at least one byte was received in that frame. Otherwise the frame ends with no pulse at all.
- R5: A character that is neither valid nor all-zero (for example, a nonzero data byte with a low stop bit) gives one `frame_err` pulse and no byte, and returns the receiver to idle.
- R6: While a start bit is expected, up to 25 consecutive high samples are tolerated. The 26th high sample gives a `frame_err` pulse and a return to idle.
- R7: The byte that brings the frame to `MAX_BYTES` bytes is still delivered, and `frame_err` pulses in the same cycle. The receiver then returns to idle, so it never holds more than `MAX_BYTES` bytes.
- R8: After reset, `byte_vld`, `frame_done`, `frame_err` and `byte_data` are all 0.
- R9: `frame_done` and `frame_err` are never 1 together. Each pulse lasts exactly one cycle and comes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Sampling strobe, four per bit period |
| rx_in | input | 1 | Serial line level |
| byte_data | output | 8 | Last received byte |
| byte_vld | output | 1 | One-cycle strobe for a new byte |
| frame_done | output | 1 | One-cycle pulse at a good end of frame |
| frame_err | output | 1 | One-cycle pulse on an aborted frame |

## Verification
The embedded assertions check on every cycle that the opening counter stays within its window, that the gap counter stays within its limit, and that the byte count never passes its maximum. They also check that completion and error never coincide, and that every output pulse follows a strobe and leaves a character-receiving state. Only the bench scenarios can show that the right bytes come out in order, and these scenarios cover all 256 byte values. They also cover the exact borders of the opening window and of the gap timeout, the silent end of an empty frame, and the insensitivity to samples away from the sampling point.

// File: rtl/sofeof_rx_pkg.sv
package sofeof_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOF  = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sofeof_rx_posctr.sv
// Sample-position counter: wraps per bit while framing bits, counts up to a
// saturating limit while waiting for a start bit.
module sofeof_rx_posctr #(
  parameter int SPB   = 4,
  parameter int SMP   = 2,
  parameter int LIMIT = 25
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          step,
  input  logic                          wrap,
  output logic [$clog2(LIMIT+2)-1:0]    pos,
  output logic                          hit,
  output logic                          over
);
  localparam int PW = $clog2(LIMIT + 2);

  logic [PW-1:0] pos_inc;
  logic [PW-1:0] pos_d;

  always_comb begin
    pos_inc = (pos == PW'(LIMIT + 1)) ? pos : pos + 1'b1;
    hit     = (pos_inc == PW'(SMP));
    over    = (pos_inc > PW'(LIMIT));
    if (clr)
      pos_d = '0;
    else if (step && wrap && (pos_inc >= PW'(SPB)))
      pos_d = '0;
    else if (step)
      pos_d = pos_inc;
    else
      pos_d = pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (clr || step)
      pos <= pos_d;
  end
endmodule

// File: rtl/sofeof_rx_shreg.sv
// Right-shifting character register; new bit enters at the top.
module sofeof_rx_shreg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic [W-1:0] q_d;

  always_comb begin
    q_next = {din, q[W-1:1]};
    if (clr)
      q_d = '0;
    else if (shift)
      q_d = q_next;
    else
      q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (clr || shift)
      q <= q_d;
  end
endmodule

// File: rtl/sofeof_rx_bytecnt.sv
// Per-frame byte counter with a limit flag.
module sofeof_rx_bytecnt #(
  parameter int MAX = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic nonzero,
  output logic at_last
);
  localparam int CW = $clog2(MAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_d;

  always_comb begin
    nonzero = (cnt != '0);
    at_last = (cnt == CW'(MAX - 1));
    if (clr)
      cnt_d = '0;
    else if (inc)
      cnt_d = cnt + 1'b1;
    else
      cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr || inc)
      cnt <= cnt_d;
  end

  // R7: count never exceeds the configured frame limit
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX));
endmodule

// File: rtl/sofeof_rx.sv
module sofeof_rx
  import sofeof_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SPB       = 4,
  parameter int SMP_POS   = 2,
  parameter int SOF_MIN   = 10,
  parameter int SOF_MAX   = 12,
  parameter int GAP_MAX   = 25,
  parameter int MAX_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              rx_in,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              frame_done,
  output logic              frame_err
);
  localparam int CHAR_W = DATA_W + 2;
  localparam int BMAX   = (SOF_MAX > CHAR_W) ? SOF_MAX : CHAR_W;
  localparam int BW     = $clog2(BMAX + 2);
  localparam int PW     = $clog2(GAP_MAX + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  rx_state_e          st, st_n;
  logic [BW-1:0]      bitc, bitc_inc;
  logic [PW-1:0]      pos;
  logic               pos_hit, pos_over;
  logic               pos_clr, pos_step, pos_wrap;
  logic               bit_clr, bit_inc;
  logic               sh_clr, sh_shift;
  logic [CHAR_W-1:0]  sh_q, sh_next;
  logic               bc_clr, bc_inc, bc_nz, bc_last;
  logic               vld_n, done_n, err_n;
  logic               char_ok, char_eof;

  sofeof_rx_posctr #(.SPB(SPB), .SMP(SMP_POS), .LIMIT(GAP_MAX)) u_pos (
    .clk(clk), .rst_n(rst_n_s), .clr(pos_clr), .step(pos_step),
    .wrap(pos_wrap), .pos(pos), .hit(pos_hit), .over(pos_over)
  );

  sofeof_rx_shreg #(.W(CHAR_W)) u_sh (
    .clk(clk), .rst_n(rst_n_s), .clr(sh_clr), .shift(sh_shift),
    .din(rx_in), .q(sh_q), .q_next(sh_next)
  );

  sofeof_rx_bytecnt #(.MAX(MAX_BYTES)) u_bc (
    .clk(clk), .rst_n(rst_n_s), .clr(bc_clr), .inc(bc_inc),
    .nonzero(bc_nz), .at_last(bc_last)
  );

  assign bitc_inc = bitc + 1'b1;
  assign char_ok  = sh_next[CHAR_W-1] && !sh_next[0];
  assign char_eof = (sh_next == '0);

  // next-state logic
  always_comb begin
    st_n     = st;
    pos_clr  = 1'b0;
    pos_step = 1'b0;
    pos_wrap = 1'b0;
    bit_clr  = 1'b0;
    bit_inc  = 1'b0;
    sh_clr   = 1'b0;
    sh_shift = 1'b0;
    bc_clr   = 1'b0;
    bc_inc   = 1'b0;
    vld_n    = 1'b0;
    done_n   = 1'b0;
    err_n    = 1'b0;
    if (smp_en) begin
      unique case (st)
        ST_IDLE: begin
          if (!rx_in) begin
            st_n    = ST_SOF;
            pos_clr = 1'b1;
            bit_clr = 1'b1;
          end
        end
        ST_SOF: begin
          pos_step = 1'b1;
          pos_wrap = 1'b1;
          if (pos_hit) begin
            if (rx_in) begin
              if (bitc >= BW'(SOF_MIN)) begin
                st_n    = ST_GAP;
                pos_clr = 1'b1;
                bc_clr  = 1'b1;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              bit_inc = 1'b1;
              if (bitc_inc > BW'(SOF_MAX))
                st_n = ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (rx_in) begin
            pos_step = 1'b1;
            if (pos_over) begin
              st_n  = ST_IDLE;
              err_n = 1'b1;
            end
          end else begin
            st_n    = ST_DATA;
            pos_clr = 1'b1;
            bit_clr = 1'b1;
            sh_clr  = 1'b1;
          end
        end
        ST_DATA: begin
          pos_step = 1'b1;
          pos_wrap = 1'b1;
          if (pos_hit) begin
            sh_shift = 1'b1;
            bit_inc  = 1'b1;
            if (bitc_inc == BW'(CHAR_W)) begin
              if (char_ok) begin
                vld_n  = 1'b1;
                bc_inc = 1'b1;
                if (bc_last) begin
                  st_n  = ST_IDLE;
                  err_n = 1'b1;
                end else begin
                  st_n    = ST_GAP;
                  pos_clr = 1'b1;
                end
              end else if (char_eof) begin
                st_n   = ST_IDLE;
                done_n = bc_nz;
              end else begin
                st_n  = ST_IDLE;
                err_n = 1'b1;
              end
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st         <= ST_IDLE;
      bitc       <= '0;
      byte_data  <= '0;
      byte_vld   <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      st         <= st_n;
      byte_vld   <= vld_n;
      frame_done <= done_n;
      frame_err  <= err_n;
      if (bit_clr)
        bitc <= '0;
      else if (bit_inc)
        bitc <= bitc_inc;
      if (vld_n)
        byte_data <= sh_next[DATA_W:1];
    end
  end

  // R2: the opening counter never passes its window while opening
  a_r2_sof_window: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_SOF) |-> (bitc <= BW'(SOF_MAX)));

  // R6: quiet time while awaiting a start bit stays within its limit
  a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_GAP) |-> (pos <= PW'(GAP_MAX)));

  // R9: completion and error are exclusive
  a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(frame_done && frame_err));

  // R1/R9: every output pulse follows a sampling strobe
  a_r1_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n_s)
    (byte_vld || frame_done || frame_err) |-> $past(smp_en));

  // R3: bytes come only out of character reception
  a_r3_vld_from_data: assert property (@(posedge clk) disable iff (!rst_n_s)
    byte_vld |-> ($past(st) == ST_DATA));

  // R4: completion only at the close of a character
  a_r4_done_from_data: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_done |-> ($past(st) == ST_DATA));
endmodule

// File: tb/sofeof_rx_tb_top.sv
module sofeof_rx_tb_top;
  localparam int MAXB = 4;

  logic       clk;
  logic       rst_n;
  logic       smp_en;
  logic       rx_in;
  logic [7:0] byte_data;
  logic       byte_vld, frame_done, frame_err;

  int n_checks = 0;
  int n_fail   = 0;
  int n_bytes, n_done, n_err, n_both, n_long;
  logic [7:0] log_q [16];
  logic prev_pulse;

  sofeof_rx #(.MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rx_in(rx_in),
    .byte_data(byte_data), .byte_vld(byte_vld),
    .frame_done(frame_done), .frame_err(frame_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin
        if (n_bytes < 16) log_q[n_bytes] = byte_data;
        n_bytes++;
      end
      if (frame_done) n_done++;
      if (frame_err) n_err++;
      if (frame_done && frame_err) n_both++;
      if (prev_pulse && (frame_done || frame_err)) n_long++;
      prev_pulse = frame_done || frame_err;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    #1;
    n_bytes = 0; n_done = 0; n_err = 0;
  endtask

  // one strobed sample; the line is inverted between strobes (R1)
  task automatic smp(input logic b);
    @(negedge clk);
    rx_in = b; smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0; rx_in = ~b;
  endtask

  task automatic bitv(input logic b);
    repeat (4) smp(b);
  endtask

  // value present only at the sampling point (index 2)
  task automatic bitmid(input logic b);
    smp(~b); smp(~b); smp(b); smp(~b);
  endtask

  task automatic sof(input int k);
    repeat (4 * k) smp(1'b0);
    bitv(1'b1);
  endtask

  task automatic chr(input logic [7:0] d);
    bitv(1'b0);
    for (int i = 0; i < 8; i++) bitv(d[i]);
    bitv(1'b1);
  endtask

  task automatic eof();
    repeat (10) bitv(1'b0);
  endtask

  task automatic tail();
    repeat (6) smp(1'b1);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic flush();
    repeat (40) smp(1'b1);
    clear_log();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_en = 1'b0; rx_in = 1'b1;
    n_bytes = 0; n_done = 0; n_err = 0; n_both = 0; n_long = 0;
    prev_pulse = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R8 reset state
    chk("R8 byte_vld", int'(byte_vld), 0);
    chk("R8 frame_done", int'(frame_done), 0);
    chk("R8 frame_err", int'(frame_err), 0);
    chk("R8 byte_data", int'(byte_data), 0);

    // R2 opening window sweep
    for (int k = 9; k <= 13; k++) begin
      automatic int acc = (k >= 10 && k <= 12) ? 1 : 0;
      flush();
      sof(k); chr(8'hA5); eof(); tail();
      chk($sformatf("R2 bytes k=%0d", k), n_bytes, acc);
      chk($sformatf("R2 done k=%0d", k), n_done, acc);
      chk($sformatf("R2 err k=%0d", k), n_err, 0);
      if (acc == 1) chk($sformatf("R2 data k=%0d", k), int'(log_q[0]), 8'hA5);
    end

    // R3/R4 all byte values, three per frame
    for (int v = 0; v < 256; v += 3) begin
      flush();
      sof(10 + (v % 3));
      for (int j = 0; j < 3; j++) chr(8'((v + j) % 256));
      eof(); tail();
      chk($sformatf("R3 count v=%0d", v), n_bytes, 3);
      for (int j = 0; j < 3; j++)
        chk($sformatf("R3 byte v=%0d j=%0d", v, j), int'(log_q[j]), (v + j) % 256);
      chk($sformatf("R4 done v=%0d", v), n_done, 1);
      chk($sformatf("R5 no err v=%0d", v), n_err, 0);
    end

    // R4 empty frame closes silently
    flush();
    sof(10); eof(); tail();
    chk("R4 empty done", n_done, 0);
    chk("R4 empty err", n_err, 0);
    chk("R4 empty bytes", n_bytes, 0);

    // R5 malformed character: nonzero data, low stop bit
    flush();
    sof(11); chr(8'h3C);
    bitv(1'b0);
    for (int i = 0; i < 8; i++) bitv(i == 0 || i == 7);
    bitv(1'b0);
    tail();
    chk("R5 bytes", n_bytes, 1);
    chk("R5 err", n_err, 1);
    chk("R5 done", n_done, 0);

    // R6 gap border: 25 highs tolerated (1 already after opening)
    flush();
    sof(10); repeat (24) smp(1'b1); chr(8'h11);
    repeat (24) smp(1'b1); chr(8'h22); eof(); tail();
    chk("R6 gap25 bytes", n_bytes, 2);
    chk("R6 gap25 done", n_done, 1);
    chk("R6 gap25 err", n_err, 0);
    flush();
    sof(10); repeat (25) smp(1'b1); tail();
    chk("R6 gap26 err", n_err, 1);
    flush();
    sof(10); chr(8'h7E); repeat (25) smp(1'b1); tail();
    chk("R6 gap26 after byte err", n_err, 1);
    chk("R6 gap26 after byte bytes", n_bytes, 1);

    // R7 frame limit
    flush();
    sof(12);
    for (int j = 0; j < MAXB; j++) chr(8'(8'h80 + j));
    tail();
    chk("R7 bytes", n_bytes, MAXB);
    chk("R7 last byte", int'(log_q[MAXB-1]), 8'h80 + MAXB - 1);
    chk("R7 err", n_err, 1);
    chk("R7 done", n_done, 0);

    // R1 long unstrobed low stretch and mid-point-only bits
    flush();
    sof(10); chr(8'h5A);
    @(negedge clk); rx_in = 1'b0;
    repeat (50) @(negedge clk);
    for (int i = 0; i < 1; i++) begin
      bitv(1'b0);
      for (int b = 0; b < 8; b++) bitmid(b % 2 == 1);
      bitmid(1'b1);
    end
    eof(); tail();
    chk("R1 bytes", n_bytes, 2);
    chk("R1 first", int'(log_q[0]), 8'h5A);
    chk("R1 midpoint byte", int'(log_q[1]), 8'hAA);
    chk("R1 done", n_done, 1);

    flush();
    chk("R9 done+err together", n_both, 0);
    chk("R9 pulse wider than one cycle", n_long, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule